// File: doc/BRIEF.md
# External Control and Skip-Test Decoder

This block sits beside the instruction sequencer and handles the two I/O instruction classes that talk to external devices without moving data. For an activate instruction, the leading octal digit of the 15-bit address field picks the kind of control signal. Digit 0 gives a buffer-control level that lasts the whole window. Digit 1 gives a single-clock I/O-control pulse. Digit 3 gives a single-clock external-control pulse. The low twelve address bits are presented on output lines so that external logic can gate them with those signals.

For a sense instruction, the low two bits of the leading digit choose one of two external test inputs. A leading digit of 1 selects test input 1, and a leading digit of 3 selects test input 2. The block answers with a one-clock skip decision in the last cycle of the window. A test input that is high counts as true. A line left unconnected is pulled high at the board, so it reads as true and causes a skip. The low twelve address bits are driven out during a sense as well, so that external logic can fold them into the tested signal.

A sequencer state machine with five states runs each instruction window. IDLE waits for a strobe. The activate path takes IDLE→ACT_PULSE (first window cycle, where a pulse can fire) →ACT_HOLD (the remaining cycles) →IDLE. The sense path takes IDLE→SNS_HOLD (all window cycles but the last) →SNS_DECIDE (last cycle, where the skip is reported) →IDLE. Every window is `WIN_LEN` clocks long, and `WIN_LEN` must be at least 2.

Top module: `xsd_ctl_skip_decoder`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, win_o, addr_o, bufctl_o, ioc_pulse_o, exc_pulse_o and skip_o are all 0.
- R2: An activate instruction (op_cls_i = 1) whose leading digit addr_fld_i[14:12] equals 0 holds bufctl_o high in every window cycle and produces no pulse.
- R3: An activate instruction with leading digit 1 raises ioc_pulse_o for exactly one clock, in the first window cycle.
- R4: An activate instruction with leading digit 3 raises exc_pulse_o for exactly one clock, in the first window cycle.
- R5: During every window, addr_o equals addr_fld_i[11:0] as captured with the strobe, and it stays stable even if addr_fld_i changes. Outside a window, addr_o is 0.
- R6: A sense instruction (op_cls_i = 2) reports its decision on skip_o for exactly one clock, in the last window cycle. Address bit 13 picks the input: with bits 14:12 = 001 it uses test1_i, and with 011 it uses test2_i. The selected input is sampled in that last cycle.
- R7: The selected test input being high (as an unconnected, pulled-high line is) gives skip_o = 1. Low gives skip_o = 0.
- R8: Leading digits other than 0, 1 and 3 on activate, and other than 1 and 3 on sense, produce no control output and no skip. addr_o is still driven during the window.
- R9: The strobe instr_vld_i is ignored while a window is running, and it is also ignored with op_cls_i equal to 0 (none) or 3 (reserved).
- R10: Each accepted instruction keeps win_o high for exactly WIN_LEN consecutive clocks, the first being the cycle after the strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| instr_vld_i | input | 1 | One-clock instruction strobe |
| op_cls_i | input | 2 | 0 none, 1 activate, 2 sense, 3 reserved |
| addr_fld_i | input | 15 | Address field; bits 14:12 are the leading octal digit |
| test1_i | input | 1 | External test input 1 |
| test2_i | input | 1 | External test input 2 |
| win_o | output | 1 | Instruction window active |
| addr_o | output | 12 | Captured low address bits for external gating |
| bufctl_o | output | 1 | Buffer-control level |
| ioc_pulse_o | output | 1 | I/O-control pulse |
| exc_pulse_o | output | 1 | External-control pulse |
| skip_o | output | 1 | Skip decision |

## Verification
The bench builds the block with WIN_LEN = 3. This is the shortest window in which ACT_HOLD and SNS_HOLD each run for more than one cycle, so the counter's exit compare is exercised, not just its entry. It also keeps every window short enough that each cycle of it is inspected, including the cycle that follows. At this length, a strobe issued in the middle of a window lands squarely inside a hold state, which puts the busy-ignore rule within reach.

// File: rtl/xsd_pkg.sv
package xsd_pkg;

    typedef enum logic [1:0] {
        CLS_NONE     = 2'd0,
        CLS_ACTIVATE = 2'd1,
        CLS_SENSE    = 2'd2,
        CLS_RSVD     = 2'd3
    } op_cls_e;

    typedef enum logic [2:0] {
        ST_IDLE       = 3'd0,
        ST_ACT_PULSE  = 3'd1,
        ST_ACT_HOLD   = 3'd2,
        ST_SNS_HOLD   = 3'd3,
        ST_SNS_DECIDE = 3'd4
    } win_state_e;

    typedef enum logic [1:0] {
        CK_NONE   = 2'd0,
        CK_BUFCTL = 2'd1,
        CK_IOCTL  = 2'd2,
        CK_EXTCTL = 2'd3
    } ctl_kind_e;

    localparam int unsigned DIGIT_BUFCTL = 0;
    localparam int unsigned DIGIT_IOCTL  = 1;
    localparam int unsigned DIGIT_EXTCTL = 3;

endpackage

// File: rtl/xsd_digit_decode.sv
module xsd_digit_decode
    import xsd_pkg::*;
#(
    parameter int unsigned DIGIT_W = 3
) (
    input  logic [DIGIT_W-1:0] digit_i,
    output ctl_kind_e          kind_o
);
    localparam logic [DIGIT_W-1:0] D_BUF = DIGIT_W'(DIGIT_BUFCTL);
    localparam logic [DIGIT_W-1:0] D_IOC = DIGIT_W'(DIGIT_IOCTL);
    localparam logic [DIGIT_W-1:0] D_EXC = DIGIT_W'(DIGIT_EXTCTL);

    always_comb begin
        if (digit_i == D_BUF)      kind_o = CK_BUFCTL;
        else if (digit_i == D_IOC) kind_o = CK_IOCTL;
        else if (digit_i == D_EXC) kind_o = CK_EXTCTL;
        else                       kind_o = CK_NONE;
    end
endmodule

// File: rtl/xsd_skip_select.sv
module xsd_skip_select #(
    parameter int unsigned DIGIT_W = 3
) (
    input  logic [DIGIT_W-1:0] digit_i,
    input  logic               test1_i,
    input  logic               test2_i,
    output logic               hit_o
);
    // Low digit bit must be set and every bit above bit 1 clear;
    // bit 1 (address bit 13) then picks the input.
    logic valid_sel;

    always_comb begin
        valid_sel = digit_i[0] && (digit_i >> 2) == '0;
        if (!valid_sel)      hit_o = 1'b0;
        else if (digit_i[1]) hit_o = test2_i;
        else                 hit_o = test1_i;
    end
endmodule

// File: rtl/xsd_window_fsm.sv
module xsd_window_fsm
    import xsd_pkg::*;
#(
    parameter int unsigned WIN_LEN = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start_i,
    input  op_cls_e    cls_i,
    output logic       accept_o,
    output win_state_e state_o
);
    localparam int unsigned   CNT_W    = $clog2(WIN_LEN + 1);
    localparam logic [CNT_W-1:0] LAST     = CNT_W'(WIN_LEN);
    localparam logic [CNT_W-1:0] PRE_LAST = CNT_W'(WIN_LEN - 1);

    win_state_e       state_q, state_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;

    always_comb begin
        accept_o = (state_q == ST_IDLE) && start_i &&
                   (cls_i == CLS_ACTIVATE || cls_i == CLS_SENSE);
        state_d = state_q;
        cnt_d   = cnt_q;
        unique case (state_q)
            ST_IDLE: begin
                if (accept_o) begin
                    cnt_d   = CNT_W'(1);
                    state_d = (cls_i == CLS_ACTIVATE) ? ST_ACT_PULSE : ST_SNS_HOLD;
                end
            end
            ST_ACT_PULSE: begin
                cnt_d   = cnt_q + 1'b1;
                state_d = ST_ACT_HOLD;
            end
            ST_ACT_HOLD: begin
                if (cnt_q == LAST) state_d = ST_IDLE;
                else               cnt_d   = cnt_q + 1'b1;
            end
            ST_SNS_HOLD: begin
                if (cnt_q == PRE_LAST) state_d = ST_SNS_DECIDE;
                else                   cnt_d   = cnt_q + 1'b1;
            end
            ST_SNS_DECIDE: state_d = ST_IDLE;
            default:       state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    assign state_o = state_q;

    assert_pulse_then_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        state_q == ST_ACT_PULSE |=> state_q == ST_ACT_HOLD);
    assert_hold_until_last_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_ACT_HOLD && cnt_q != LAST) |=> state_q == ST_ACT_HOLD);
    assert_decide_once_R6: assert property (@(posedge clk) disable iff (!rst_n)
        state_q == ST_SNS_DECIDE |=> state_q == ST_IDLE);
    assert_bad_class_ignored_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && (cls_i == CLS_NONE || cls_i == CLS_RSVD)) |=> state_q == ST_IDLE);
endmodule

// File: rtl/xsd_ctl_skip_decoder.sv
module xsd_ctl_skip_decoder
    import xsd_pkg::*;
#(
    parameter int unsigned ADDR_W  = 15,
    parameter int unsigned OUT_W   = 12,
    parameter int unsigned WIN_LEN = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              instr_vld_i,
    input  logic [1:0]        op_cls_i,
    input  logic [ADDR_W-1:0] addr_fld_i,
    input  logic              test1_i,
    input  logic              test2_i,
    output logic              win_o,
    output logic [OUT_W-1:0]  addr_o,
    output logic              bufctl_o,
    output logic              ioc_pulse_o,
    output logic              exc_pulse_o,
    output logic              skip_o
);
    localparam int unsigned DIGIT_W = ADDR_W - OUT_W;

    win_state_e        state;
    logic              accept;
    logic [ADDR_W-1:0] fld_q;
    ctl_kind_e         kind;
    logic              hit;

    xsd_window_fsm #(.WIN_LEN(WIN_LEN)) u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .start_i  (instr_vld_i),
        .cls_i    (op_cls_e'(op_cls_i)),
        .accept_o (accept),
        .state_o  (state)
    );

    always_ff @(posedge clk) begin
        if (!rst_n)      fld_q <= '0;
        else if (accept) fld_q <= addr_fld_i;
    end

    xsd_digit_decode #(.DIGIT_W(DIGIT_W)) u_dec (
        .digit_i (fld_q[ADDR_W-1:OUT_W]),
        .kind_o  (kind)
    );

    xsd_skip_select #(.DIGIT_W(DIGIT_W)) u_skip (
        .digit_i (fld_q[ADDR_W-1:OUT_W]),
        .test1_i (test1_i),
        .test2_i (test2_i),
        .hit_o   (hit)
    );

    always_comb begin
        win_o       = 1'b0;
        addr_o      = '0;
        bufctl_o    = 1'b0;
        ioc_pulse_o = 1'b0;
        exc_pulse_o = 1'b0;
        skip_o      = 1'b0;
        unique case (state)
            ST_IDLE: ;
            ST_ACT_PULSE: begin
                win_o       = 1'b1;
                addr_o      = fld_q[OUT_W-1:0];
                bufctl_o    = (kind == CK_BUFCTL);
                ioc_pulse_o = (kind == CK_IOCTL);
                exc_pulse_o = (kind == CK_EXTCTL);
            end
            ST_ACT_HOLD: begin
                win_o    = 1'b1;
                addr_o   = fld_q[OUT_W-1:0];
                bufctl_o = (kind == CK_BUFCTL);
            end
            ST_SNS_HOLD: begin
                win_o  = 1'b1;
                addr_o = fld_q[OUT_W-1:0];
            end
            ST_SNS_DECIDE: begin
                win_o  = 1'b1;
                addr_o = fld_q[OUT_W-1:0];
                skip_o = hit;
            end
            default: ;
        endcase
    end

    assert_one_ctl_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({bufctl_o, ioc_pulse_o, exc_pulse_o}));
    assert_ioc_single_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ioc_pulse_o |=> !ioc_pulse_o);
    assert_exc_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
        exc_pulse_o |=> !exc_pulse_o);
    assert_addr_stable_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (win_o && $past(win_o)) |-> $stable(addr_o));
    assert_idle_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !win_o |-> (addr_o == '0 && !bufctl_o && !ioc_pulse_o && !exc_pulse_o && !skip_o));
    assert_skip_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
        skip_o |=> !win_o);
endmodule

// File: tb/sim_xsd_ctl_skip_decoder.sv
module sim_xsd_ctl_skip_decoder;
    localparam int W = 3;
    localparam int NV = 12;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        vld = 1'b0;
    logic [1:0]  cls = 2'd0;
    logic [14:0] fld = '0;
    logic        t1 = 1'b0, t2 = 1'b0;
    logic        win, bufctl, ioc, exc, skip;
    logic [11:0] addr;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    xsd_ctl_skip_decoder #(.ADDR_W(15), .OUT_W(12), .WIN_LEN(W)) u0 (
        .clk(clk), .rst_n(rst_n), .instr_vld_i(vld), .op_cls_i(cls),
        .addr_fld_i(fld), .test1_i(t1), .test2_i(t2), .win_o(win),
        .addr_o(addr), .bufctl_o(bufctl), .ioc_pulse_o(ioc),
        .exc_pulse_o(exc), .skip_o(skip)
    );

    // {cls[1:0], field[14:0], t1, t2, buf, ioc, exc, skip}
    localparam logic [22:0] VEC [NV] = '{
        {2'd1, 15'o01234, 2'b00, 4'b1000},
        {2'd1, 15'o17654, 2'b00, 4'b0100},
        {2'd1, 15'o37070, 2'b00, 4'b0010},
        {2'd1, 15'o20001, 2'b11, 4'b0000},
        {2'd1, 15'o77777, 2'b11, 4'b0000},
        {2'd2, 15'o10000, 2'b10, 4'b0001},
        {2'd2, 15'o10000, 2'b01, 4'b0000},
        {2'd2, 15'o34567, 2'b01, 4'b0001},
        {2'd2, 15'o34567, 2'b10, 4'b0000},
        {2'd2, 15'o52525, 2'b11, 4'b0000},
        {2'd2, 15'o03333, 2'b11, 4'b0000},
        {2'd2, 15'o11111, 2'b11, 4'b0001}
    };

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic quiet(input string req);
        chk(!win && addr == 0 && !bufctl && !ioc && !exc && !skip, req,
            {win, bufctl, ioc, exc, skip, addr}, 0);
    endtask

    task automatic run_vec(input logic [22:0] v);
        logic [14:0] f;
        int nbuf, nioc, nexc, nskip, nwin, badaddr;
        bit ioc1, exc1, skiplast, odd;
        string tag;
        f = v[20:6];
        odd = (v[22:21] == 2'd1) ? !(f[14:12] inside {3'd0, 3'd1, 3'd3})
                                 : !(f[14:12] inside {3'd1, 3'd3});
        tag = odd ? "R8" : "";
        @(negedge clk);
        vld = 1'b1; cls = v[22:21]; fld = f; t1 = v[5]; t2 = v[4];
        @(negedge clk);
        vld = 1'b0; cls = 2'd0; fld = ~f;
        nbuf = 0; nioc = 0; nexc = 0; nskip = 0; nwin = 0; badaddr = 0;
        ioc1 = 0; exc1 = 0; skiplast = 0;
        for (int c = 1; c <= W; c++) begin
            if (win) nwin++;
            if (bufctl) nbuf++;
            if (ioc) begin nioc++; if (c == 1) ioc1 = 1; end
            if (exc) begin nexc++; if (c == 1) exc1 = 1; end
            if (skip) begin nskip++; if (c == W) skiplast = 1; end
            if (addr != f[11:0]) badaddr++;
            if (c < W) @(negedge clk);
        end
        chk(nwin == W, {"R10 window length ", tag}, nwin, W);
        chk(badaddr == 0, {"R5 address held ", tag}, badaddr, 0);
        chk(nbuf == (v[3] ? W : 0), {"R2 bufctl cycles ", tag}, nbuf, v[3] ? W : 0);
        chk(nioc == int'(v[2]) && ioc1 == v[2], {"R3 ioc pulse ", tag}, nioc, v[2]);
        chk(nexc == int'(v[1]) && exc1 == v[1], {"R4 exc pulse ", tag}, nexc, v[1]);
        chk(nskip == int'(v[0]) && skiplast == v[0], {"R6 R7 skip ", tag}, nskip, v[0]);
        @(negedge clk);
        quiet("R5 idle after window");
        t1 = 1'b0; t2 = 1'b0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        int nioc, nskip, badaddr;
        // R1 reset state
        repeat (3) @(negedge clk);
        quiet("R1 in reset");
        rst_n = 1'b1;
        @(negedge clk);
        quiet("R1 after reset");

        for (int i = 0; i < NV; i++) run_vec(VEC[i]);

        // R9 class none and reserved are ignored
        for (int k = 0; k < 2; k++) begin
            @(negedge clk);
            vld = 1'b1; cls = (k == 0) ? 2'd0 : 2'd3; fld = 15'o17777;
            @(negedge clk);
            vld = 1'b0; cls = 2'd0;
            quiet("R9 bad class ignored");
        end

        // R9 strobe during a running window is ignored
        @(negedge clk);
        vld = 1'b1; cls = 2'd1; fld = 15'o12222;
        @(negedge clk);
        vld = 1'b1; cls = 2'd2; fld = 15'o30000; t2 = 1'b1;
        nioc = 0; nskip = 0; badaddr = 0;
        for (int c = 1; c <= W; c++) begin
            if (ioc) nioc++;
            if (skip) nskip++;
            if (addr != 12'o2222) badaddr++;
            @(negedge clk);
            vld = 1'b0; cls = 2'd0;
        end
        chk(nioc == 1 && badaddr == 0, "R9 busy strobe keeps first instr", nioc + badaddr, 1);
        chk(nskip == 0, "R9 busy sense not started", nskip, 0);
        quiet("R9 idle after busy window");
        @(negedge clk);
        quiet("R9 no late window");
        t2 = 1'b0;

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule